// File: doc/BRIEF.md
# Paged Virtual-to-Physical Address Relocator

This block maps a 16-bit virtual address onto an 18-bit physical bus address. The top three virtual address bits pick one of eight pages, and a mode input picks one of two register banks (kernel or user). Each page has a base register and a descriptor register. The base, shifted left by six, is added to the 13-bit page offset. The descriptor holds the page length, the direction the page grows in, and the access rights. An access that breaks the length or the access rights raises an abort in the same cycle. The status registers record which check failed, the mode, the page, and the virtual address that caused the fault.

The processor drives `va`, `user_mode`, `is_write`, `xlate_en` and `acc_valid`, and uses `pa` combinationally. Software reaches every base, descriptor and status register through a word-wide port. Each register sits at its own fixed, non-contiguous bus byte address. Reads are combinational. Writes take effect on the next rising clock edge. When `xlate_en` is low, addresses pass through untranslated, except that the top 8 KB page is folded onto the top of the 18-bit space.

Top module: `page_reloc`

## Requirements
- R1: After reset, all 32 page registers and both status registers read zero, and `abort` is low.
- R2: The 16 base registers are at octal 172340+2p (kernel) and 177640+2p (user), for page p. They hold 12 bits, and read bits 15:12 as zero. The descriptors are at octal 172300+2p (kernel) and 177600+2p (user). A descriptor keeps the length in bits 14:8, the downward-growth bit in bit 3 and the access code in bits 2:1, and reads all other bits as zero.
- R3: `va[15:13]` selects the page. `user_mode`=1 selects the user bank and 0 selects the kernel bank. The two banks are fully separate.
- R4: With `xlate_en`=1, `pa` = (base << 6) + `va[12:0]`, taken modulo 2^18. For example, base octal 000501 with offset octal 07776 gives octal 060076.
- R5: With `xlate_en`=0, `pa` = {2'b00, `va`} for pages 0 to 6. For page 7, `pa` = 18'h3E000 + `va[12:0]`. `abort` stays low in this mode.
- R6: The block number is `va[12:6]`. If the downward bit is 0, a block number greater than the length is a length fault. If the downward bit is 1, a block number less than the length is a length fault.
- R7: Access code 00 or 10 is a non-resident fault. Access code 01 with `is_write`=1 is a read-only fault. Access code 11 never faults. `abort` = `xlate_en` & `acc_valid` & (any fault).
- R8: On a rising edge with `abort` high, capture is enabled when the SR0 fault flags are zero and software is not writing SR0. When enabled, SR0 (octal 177572) takes the non-resident flag in bit 15, the length flag in bit 14, the read-only flag in bit 13, the mode (11 for user, 00 for kernel) in bits 6:5 and the page in bits 3:1. SR2 (octal 177576) takes `va`.
- R9: While any SR0 bit 15:13 is set, further aborts still drive `abort` but leave SR0 and SR2 unchanged.
- R10: Software can set and clear SR0 bits 15:13, 6:5 and 3:1 individually, and reads back exactly what it wrote. SR0 reads its other bits as zero. SR2 ignores writes.
- R11: If a software write to SR0 falls in the same cycle as an abort, the written value lands in SR0 and SR2 keeps its old value.
- R12: The reserved status register at octal 172516, and any address that is not mapped, read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| va | input | 16 | Virtual address |
| user_mode | input | 1 | 1 selects the user bank, 0 the kernel bank |
| is_write | input | 1 | Access is a write |
| xlate_en | input | 1 | Translation enable |
| acc_valid | input | 1 | An access is presented this cycle |
| pa | output | 18 | Physical address |
| abort | output | 1 | Access violates length or rights |
| reg_addr | input | 16 | Register port byte address |
| reg_wdata | input | 16 | Register port write data |
| reg_we | input | 1 | Register port write strobe |
| reg_rdata | output | 16 | Register port read data |

## Verification
A faulting access can coincide with software writing SR0, and in that case the capture and the write compete for the same register. The bench creates this by raising a read-only fault in the same clock cycle as a write of a single length flag to SR0. It then expects SR0 to read back only the written value, and SR2 to keep the address from the previous capture. A related pairing is a second fault arriving while the flags are still set. In that case `abort` must still be high while both status registers stay unchanged.

// File: rtl/page_reloc.sv
module page_reloc #(
  parameter int VA_W  = 16,
  parameter int PA_W  = 18,
  parameter int BASE_W = 12,
  parameter int LEN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   va,
  input  logic              user_mode,
  input  logic              is_write,
  input  logic              xlate_en,
  input  logic              acc_valid,
  output logic [PA_W-1:0]   pa,
  output logic              abort,
  input  logic [15:0]       reg_addr,
  input  logic [15:0]       reg_wdata,
  input  logic              reg_we,
  output logic [15:0]       reg_rdata
);
  localparam int OFF_W = VA_W - 3;
  localparam int SHIFT = OFF_W - LEN_W;
  localparam int NREG  = 16;
  localparam logic [15:0] KDSC_AT = 16'o172300;
  localparam logic [15:0] KBAS_AT = 16'o172340;
  localparam logic [15:0] UDSC_AT = 16'o177600;
  localparam logic [15:0] UBAS_AT = 16'o177640;
  localparam logic [15:0] SR0_AT  = 16'o177572;
  localparam logic [15:0] SR2_AT  = 16'o177576;

  logic [BASE_W-1:0] base_q [NREG];
  logic [LEN_W-1:0]  len_q  [NREG];
  logic              down_q [NREG];
  logic [1:0]        rig_q  [NREG];
  logic [2:0]        sr0_flags;
  logic [1:0]        sr0_mode;
  logic [2:0]        sr0_page;
  logic [VA_W-1:0]   sr2_q;

  logic       in_kdsc, in_kbas, in_udsc, in_ubas;
  logic [3:0] widx;
  assign in_kdsc = !reg_addr[0] && reg_addr[15:4] == KDSC_AT[15:4];
  assign in_kbas = !reg_addr[0] && reg_addr[15:4] == KBAS_AT[15:4];
  assign in_udsc = !reg_addr[0] && reg_addr[15:4] == UDSC_AT[15:4];
  assign in_ubas = !reg_addr[0] && reg_addr[15:4] == UBAS_AT[15:4];
  assign widx    = {in_udsc | in_ubas, reg_addr[3:1]};

  logic sr0_we;
  assign sr0_we = reg_we && reg_addr == SR0_AT;

  logic [2:0]       pg;
  logic [3:0]       tidx;
  logic [OFF_W-1:0] off;
  logic [LEN_W-1:0] blk;
  assign pg   = va[VA_W-1:OFF_W];
  assign tidx = {user_mode, pg};
  assign off  = va[OFF_W-1:0];
  assign blk  = va[OFF_W-1:SHIFT];

  logic [PA_W-1:0] reloc, direct;
  assign reloc  = PA_W'({base_q[tidx], 6'b0}) + PA_W'(off);
  assign direct = (&pg) ? {{(PA_W-OFF_W){1'b1}}, off} : PA_W'(va);
  assign pa     = xlate_en ? reloc : direct;

  logic f_nonres, f_len, f_ro;
  assign f_nonres = !rig_q[tidx][0];
  assign f_len    = down_q[tidx] ? (blk < len_q[tidx]) : (blk > len_q[tidx]);
  assign f_ro     = rig_q[tidx] == 2'b01 && is_write;
  assign abort    = xlate_en && acc_valid && (f_nonres || f_len || f_ro);

  logic capture;
  assign capture = abort && sr0_flags == 3'b000 && !sr0_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= '0;
        len_q[i]  <= '0;
        down_q[i] <= 1'b0;
        rig_q[i]  <= 2'b00;
      end
    end else if (reg_we) begin
      if (in_kbas || in_ubas) base_q[widx] <= reg_wdata[BASE_W-1:0];
      if (in_kdsc || in_udsc) begin
        len_q[widx]  <= reg_wdata[8 +: LEN_W];
        down_q[widx] <= reg_wdata[3];
        rig_q[widx]  <= reg_wdata[2:1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr0_flags <= '0;
      sr0_mode  <= '0;
      sr0_page  <= '0;
      sr2_q     <= '0;
    end else if (sr0_we) begin
      sr0_flags <= reg_wdata[15:13];
      sr0_mode  <= reg_wdata[6:5];
      sr0_page  <= reg_wdata[3:1];
    end else if (capture) begin
      sr0_flags <= {f_nonres, f_len, f_ro};
      sr0_mode  <= {2{user_mode}};
      sr0_page  <= pg;
      sr2_q     <= va;
    end
  end

  logic [3:0] ridx;
  assign ridx = widx;

  always_comb begin
    reg_rdata = '0;
    if (in_kbas || in_ubas) reg_rdata = 16'(base_q[ridx]);
    else if (in_kdsc || in_udsc)
      reg_rdata = {1'b0, len_q[ridx], 4'b0, down_q[ridx], rig_q[ridx], 1'b0};
    else if (reg_addr == SR0_AT)
      reg_rdata = {sr0_flags, 6'b0, sr0_mode, 1'b0, sr0_page, 1'b0};
    else if (reg_addr == SR2_AT)
      reg_rdata = sr2_q;
  end
endmodule

module page_reloc_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] va,
  input logic        xlate_en,
  input logic        acc_valid,
  input logic [17:0] pa,
  input logic        abort,
  input logic [15:0] reg_wdata,
  input logic        sr0_we,
  input logic [2:0]  sr0_flags,
  input logic [2:0]  sr0_page,
  input logic [15:0] sr2_q
);
  assert_abort_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> xlate_en && acc_valid);

  assert_passthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!xlate_en && va[15:13] != 3'd7) |-> pa == {2'b00, va});

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && sr0_flags == 3'b000 && !sr0_we) |=> (sr2_q == $past(va) && sr0_flags != 3'b000));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sr0_flags != 3'b000 && !sr0_we) |=> ($stable(sr2_q) && $stable(sr0_page)));

  assert_sw_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sr0_we |=> sr0_flags == $past(reg_wdata[15:13]));

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (sr0_we && abort) |=> $stable(sr2_q));
endmodule

bind page_reloc page_reloc_chk u_page_reloc_chk (
  .clk(clk), .rst_n(rst_n), .va(va), .xlate_en(xlate_en), .acc_valid(acc_valid),
  .pa(pa), .abort(abort), .reg_wdata(reg_wdata), .sr0_we(sr0_we),
  .sr0_flags(sr0_flags), .sr0_page(sr0_page), .sr2_q(sr2_q)
);

// File: tb/page_reloc_bench.sv
module page_reloc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] va = '0;
  logic        user_mode = 1'b0, is_write = 1'b0, xlate_en = 1'b0, acc_valid = 1'b0;
  logic [17:0] pa;
  logic        abort;
  logic [15:0] reg_addr = '0, reg_wdata = '0, reg_rdata;
  logic        reg_we = 1'b0;
  int          n_run = 0, n_fail = 0;

  page_reloc u_page_reloc (
    .clk(clk), .rst_n(rst_n), .va(va), .user_mode(user_mode), .is_write(is_write),
    .xlate_en(xlate_en), .acc_valid(acc_valid), .pa(pa), .abort(abort),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  localparam logic [15:0] SR0 = 16'o177572, SR2 = 16'o177576, SR3 = 16'o172516;

  typedef struct packed {
    logic        usr;
    logic        wr;
    logic [15:0] v;
    logic [11:0] base;
    logic [15:0] dsc;
    logic [17:0] exp_pa;
    logic        exp_ab;
  } vec_t;

  localparam vec_t TBL [10] = '{
    '{1'b0, 1'b0, 16'h0000, 12'h000, 16'h7F06, 18'h00000, 1'b0},
    '{1'b1, 1'b1, 16'h4FFE, 12'h141, 16'h7F06, 18'h0603E, 1'b0},
    '{1'b0, 1'b0, 16'hFFFF, 12'hFFF, 16'h7F06, 18'h01FBF, 1'b0},
    '{1'b1, 1'b0, 16'h2140, 12'h010, 16'h0406, 18'h00540, 1'b1},
    '{1'b1, 1'b0, 16'h2140, 12'h010, 16'h0506, 18'h00540, 1'b0},
    '{1'b0, 1'b0, 16'h6080, 12'h020, 16'h030E, 18'h00880, 1'b1},
    '{1'b0, 1'b0, 16'h60C0, 12'h020, 16'h030E, 18'h008C0, 1'b0},
    '{1'b1, 1'b1, 16'h8000, 12'h100, 16'h7F02, 18'h04000, 1'b1},
    '{1'b1, 1'b0, 16'h8000, 12'h100, 16'h7F02, 18'h04000, 1'b0},
    '{1'b0, 1'b0, 16'hA000, 12'h001, 16'h7F00, 18'h00040, 1'b1}
  };

  function automatic logic [15:0] dsc_at(input logic usr, input logic [2:0] p);
    return (usr ? 16'o177600 : 16'o172300) + 16'(p) * 16'd2;
  endfunction
  function automatic logic [15:0] base_at(input logic usr, input logic [2:0] p);
    return (usr ? 16'o177640 : 16'o172340) + 16'(p) * 16'd2;
  endfunction
  function automatic logic [11:0] pat(input int i);
    return 12'((i * 12'h13B) ^ 12'h5A6);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [15:0] exp, input string tag);
    reg_addr = a; #1;
    chk(tag, 32'(reg_rdata), 32'(exp));
  endtask

  task automatic access(input logic usr, input logic w, input logic [15:0] v);
    @(negedge clk);
    user_mode = usr; is_write = w; va = v; acc_valid = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 abort low in reset", 32'(abort), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    xlate_en = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rd(base_at(i[3], i[2:0]), 16'h0, "R1 base reset");
      rd(dsc_at(i[3], i[2:0]), 16'h0, "R1 descriptor reset");
    end
    rd(SR0, 16'h0, "R1 SR0 reset");
    rd(SR2, 16'h0, "R1 SR2 reset");

    // table walk: R4 relocation, R6 length, R7 rights
    for (int k = 0; k < 10; k++) begin
      wr(base_at(TBL[k].usr, TBL[k].v[15:13]), 16'(TBL[k].base));
      wr(dsc_at(TBL[k].usr, TBL[k].v[15:13]), TBL[k].dsc);
      access(TBL[k].usr, TBL[k].wr, TBL[k].v);
      #1;
      chk("R4 R3 table pa", 32'(pa), 32'(TBL[k].exp_pa));
      chk("R6 R7 table abort", 32'(abort), 32'(TBL[k].exp_ab));
      acc_valid = 1'b0;
    end
    rd(SR0, 16'h0, "R8 no capture without acc_valid");

    // R8 capture, kernel non-resident page 5
    access(1'b0, 1'b0, 16'hA010);
    @(posedge clk); #1; acc_valid = 1'b0;
    rd(SR0, 16'h800A, "R8 SR0 kernel capture");
    rd(SR2, 16'hA010, "R8 SR2 capture");
    // R9 freeze
    access(1'b1, 1'b1, 16'h8002);
    #1 chk("R9 abort while frozen", 32'(abort), 32'd1);
    @(posedge clk); #1; acc_valid = 1'b0;
    rd(SR0, 16'h800A, "R9 SR0 frozen");
    rd(SR2, 16'hA010, "R9 SR2 frozen");
    // R8 user read-only capture after clear
    wr(SR0, 16'h0);
    access(1'b1, 1'b1, 16'h8004);
    @(posedge clk); #1; acc_valid = 1'b0;
    rd(SR0, 16'h2068, "R8 SR0 user capture");
    rd(SR2, 16'h8004, "R8 SR2 user capture");
    wr(SR0, 16'h0);
    // R11 write and abort in one cycle
    @(negedge clk);
    user_mode = 1'b1; is_write = 1'b1; va = 16'h8006; acc_valid = 1'b1;
    reg_addr = SR0; reg_wdata = 16'h4000; reg_we = 1'b1;
    @(posedge clk); #1; acc_valid = 1'b0; reg_we = 1'b0;
    rd(SR0, 16'h4000, "R11 write wins");
    rd(SR2, 16'h8004, "R11 SR2 kept");

    // R10 software access to SR0, SR2 read-only
    wr(SR0, 16'h8000); rd(SR0, 16'h8000, "R10 bit15");
    wr(SR0, 16'h4000); rd(SR0, 16'h4000, "R10 bit14");
    wr(SR0, 16'h2000); rd(SR0, 16'h2000, "R10 bit13");
    wr(SR0, 16'hFFFF); rd(SR0, 16'hE06E, "R10 all writable");
    wr(SR0, 16'h0000); rd(SR0, 16'h0000, "R10 clear");
    wr(SR2, 16'h1234); rd(SR2, 16'h8004, "R10 SR2 ignores write");

    // R12 reserved and unmapped
    wr(SR3, 16'hFFFF); rd(SR3, 16'h0, "R12 SR3 reads zero");
    wr(16'o177573, 16'hFFFF); rd(16'o177573, 16'h0, "R12 odd address");
    rd(SR0, 16'h0, "R12 odd write no effect");

    // R2 widths
    wr(base_at(1'b0, 3'd6), 16'hFFFF); rd(base_at(1'b0, 3'd6), 16'h0FFF, "R2 base width");
    wr(dsc_at(1'b1, 3'd6), 16'hFFFF); rd(dsc_at(1'b1, 3'd6), 16'h7F0E, "R2 descriptor fields");

    // R5 pass-through
    xlate_en = 1'b0;
    access(1'b0, 1'b0, 16'hA000);
    #1 chk("R5 low page pass", 32'(pa), 32'h0A000);
    chk("R5 no abort when off", 32'(abort), 32'd0);
    va = 16'hE123; #1 chk("R5 top page fold", 32'(pa), 32'h3E123);
    acc_valid = 1'b0;
    xlate_en = 1'b1;

    // R2 R3 full bank pattern and model check
    for (int i = 0; i < 16; i++) begin
      wr(base_at(i[3], i[2:0]), 16'(pat(i)));
      wr(dsc_at(i[3], i[2:0]), 16'h7F06);
    end
    for (int i = 0; i < 16; i++)
      rd(base_at(i[3], i[2:0]), 16'(pat(i)), "R2 R3 bank readback");
    for (int i = 0; i < 16; i++) begin
      access(i[3], 1'b0, {i[2:0], 13'h0ABC});
      #1;
      chk("R3 R4 model pa", 32'(pa), 32'((({6'd0, pat(i)}) << 6) + 18'h00ABC));
      chk("R7 full rights no abort", 32'(abort), 32'd0);
      acc_valid = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule